// File: doc/BRIEF.md
# Horizontal Scan Timer and Character-Row Counter

This block produces the horizontal timing for a small black-and-white video generator whose processor clock is the dot clock divided by two. An 8-bit scan counter advances once per processor clock. It steps through the values 1 to 207 and never takes the value 0. A one-hot decode of its two top bits gives a horizontal sync pulse of 16 clocks. A decode of its upper nibble gives the back-porch window that follows sync. A hold input parks the scan counter at 1, so surrounding logic can stall the line.

A 3-bit row counter supplies the low bits of the character-row address that is used while the processor refreshes memory. It steps once each time a sync pulse finishes. It is cleared and kept at zero while the external vertical sync is active. Its value is placed on the address pins only when the refresh input is high, and a separate enable output drives the pad buffers. A composite sync output combines the horizontal and vertical sync pulses.

Top module: `hline_timing`

## Requirements
- R1: While reset is asserted, `hcount` reads 1, the row value is 0, `hsync_n` is high and `back_porch` is high.
- R2: Outside hold and wrap, `hcount` rises by exactly 1 on each clock after reset has been released internally (two clocks after `rst_n` rises).
- R3: `hcount` changes from 207 to 1 and never leaves the range 1 to 207.
- R4: On every clock where `hold` is 1, `hcount` becomes 1. It stays at 1 for as long as `hold` stays 1.
- R5: `hsync_n` is 0 exactly when `hcount` is in the range 192 to 207, which means bits 7 and 6 are both 1. On a free-running line the pulse therefore lasts 16 clocks.
- R6: `back_porch` is 1 exactly when `hcount` is in the range 1 to 15, which means bits 7 to 4 are all 0.
- R7: The row value increases by 1, wrapping modulo 8, on the clock where `hcount` leaves the sync range. It does not change at any other time while `vsync_n` is 1.
- R8: When `vsync_n` is 0 at a clock edge, the row value becomes 0, and this takes priority over R7.
- R9: `csync_n` is 0 when `hsync_n` is 0 or `vsync_n` is 0, and is 1 otherwise.
- R10: `row_oe` equals `refresh`. `row_addr` shows the row value while `refresh` is 1 and reads 0 while `refresh` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock (half the dot clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Parks the scan counter at 1 |
| vsync_n | input | 1 | Active-low vertical sync from outside the block |
| refresh | input | 1 | High during the refresh part of a video cycle |
| hcount | output | 8 | Scan counter value |
| hsync_n | output | 1 | Active-low horizontal sync |
| back_porch | output | 1 | High during the back-porch window |
| csync_n | output | 1 | Active-low composite sync |
| row_addr | output | 3 | Row value while refresh is high, otherwise 0 |
| row_oe | output | 1 | Pad drive enable for `row_addr` |

## Verification
A long free-running stretch with no hold and no vertical sync shows the full 1 to 207 cycle, the 16-clock sync pulse, the porch window and all eight row values with their wrap. Directed holds that start inside the sync pulse and inside the active part of the line tell a hold-caused end of sync, which does advance the row, apart from a hold during the porch, which does not. Random bursts of hold, vertical sync and refresh check that the row clear wins over the advance, and that the address pins follow the refresh input in both states.

// File: rtl/hl_pkg.sv
package hl_pkg;
  localparam int HL_CNT_W     = 8;
  localparam int HL_CNT_BASE  = 1;
  localparam int HL_CNT_TOP   = 207;
  localparam int HL_PORCH_BIT = 4;
  localparam int HL_ROW_W     = 3;
  localparam int HL_SYNC_STG  = 2;
endpackage

// File: rtl/hl_rst_sync.sv
module hl_rst_sync #(
  parameter int STAGES = hl_pkg::HL_SYNC_STG
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = 1'b1;
    end else begin : g_many
      always_comb stg_d = {stg_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_q_n = stg_q[STAGES-1];
endmodule

// File: rtl/hl_hcount.sv
module hl_hcount #(
  parameter int CNT_W     = hl_pkg::HL_CNT_W,
  parameter int CNT_BASE  = hl_pkg::HL_CNT_BASE,
  parameter int CNT_TOP   = hl_pkg::HL_CNT_TOP,
  parameter int PORCH_BIT = hl_pkg::HL_PORCH_BIT
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt,
  output logic             sync_act,
  output logic             sync_end,
  output logic             porch
);
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(CNT_BASE);
  localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(CNT_TOP);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_top;
  logic             sync_nx;

  always_comb begin
    at_top = (cnt_q == TOP_V);
    cnt_en = 1'b1;
    if (hold || at_top) cnt_d = BASE_V;
    else                cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    cnt_q <= BASE_V;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    sync_act = cnt_q[CNT_W-1] & cnt_q[CNT_W-2];
    sync_nx  = cnt_d[CNT_W-1] & cnt_d[CNT_W-2];
    sync_end = sync_act & ~sync_nx;
    porch    = ~|cnt_q[CNT_W-1:PORCH_BIT];
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/hl_line_ctr.sv
module hl_line_ctr #(
  parameter int ROW_W = hl_pkg::HL_ROW_W
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             vsync_n,
  input  logic             advance,
  input  logic             refresh,
  output logic [ROW_W-1:0] line_val,
  output logic [ROW_W-1:0] row_addr,
  output logic             row_oe
);
  logic [ROW_W-1:0] line_q;
  logic [ROW_W-1:0] line_d;
  logic             line_en;

  always_comb begin
    line_en = advance | ~vsync_n;
    if (!vsync_n) line_d = '0;
    else          line_d = line_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     line_q <= '0;
    else if (line_en) line_q <= line_d;
  end

  always_comb begin
    row_oe   = refresh;
    row_addr = refresh ? line_q : '0;
  end

  assign line_val = line_q;
endmodule

// File: rtl/hline_timing.sv
module hline_timing #(
  parameter int CNT_W     = hl_pkg::HL_CNT_W,
  parameter int CNT_BASE  = hl_pkg::HL_CNT_BASE,
  parameter int CNT_TOP   = hl_pkg::HL_CNT_TOP,
  parameter int PORCH_BIT = hl_pkg::HL_PORCH_BIT,
  parameter int ROW_W     = hl_pkg::HL_ROW_W,
  parameter int SYNC_STG  = hl_pkg::HL_SYNC_STG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             vsync_n,
  input  logic             refresh,
  output logic [CNT_W-1:0] hcount,
  output logic             hsync_n,
  output logic             back_porch,
  output logic             csync_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             row_oe
);
  logic             rst_q_n;
  logic             sync_act;
  logic             sync_end;
  logic             porch;
  logic [ROW_W-1:0] line_val;

  hl_rst_sync #(.STAGES(SYNC_STG)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  hl_hcount #(
    .CNT_W(CNT_W), .CNT_BASE(CNT_BASE), .CNT_TOP(CNT_TOP), .PORCH_BIT(PORCH_BIT)
  ) i_hcnt (
    .clk(clk), .rst_q_n(rst_q_n), .hold(hold), .cnt(hcount),
    .sync_act(sync_act), .sync_end(sync_end), .porch(porch)
  );

  hl_line_ctr #(.ROW_W(ROW_W)) i_line (
    .clk(clk), .rst_q_n(rst_q_n), .vsync_n(vsync_n), .advance(sync_end),
    .refresh(refresh), .line_val(line_val), .row_addr(row_addr), .row_oe(row_oe)
  );

  always_comb begin
    hsync_n    = ~sync_act;
    back_porch = porch;
    csync_n    = ~sync_act & vsync_n;
  end
endmodule

// File: rtl/hl_timing_chk.sv
module hl_timing_chk #(
  parameter int CNT_W = 8,
  parameter int ROW_W = 3
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             hold,
  input logic             vsync_n,
  input logic             refresh,
  input logic [CNT_W-1:0] cnt,
  input logic             hsync_n,
  input logic             back_porch,
  input logic             csync_n,
  input logic [ROW_W-1:0] line,
  input logic [ROW_W-1:0] row_addr,
  input logic             row_oe
);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && !$past(hold) && $past(cnt) != CNT_W'(207))
      |-> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && $past(cnt) == CNT_W'(207)) |-> cnt == CNT_W'(1));

  a_r3_range: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |-> (cnt != '0 && cnt <= CNT_W'(207)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(hold) |-> cnt == CNT_W'(1));

  a_r5_sync_window: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |-> (!hsync_n == (cnt >= CNT_W'(192))));

  a_r6_porch_window: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |-> (back_porch == (cnt < CNT_W'(16))));

  a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && $past(vsync_n) && line != $past(line))
      |-> (line == ROW_W'($past(line) + ROW_W'(1)) && $past(!hsync_n) && hsync_n));

  a_r8_row_clear: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$past(vsync_n) |-> line == '0);

  a_r9_csync: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!vsync_n || cnt >= CNT_W'(192)) |-> !csync_n);

  a_r10_pads_off: assert property (@(posedge clk) disable iff (!rst_q_n)
    !refresh |-> (!row_oe && row_addr == '0));
endmodule

bind hline_timing hl_timing_chk #(.CNT_W(CNT_W), .ROW_W(ROW_W)) i_chk (
  .clk(clk), .rst_q_n(rst_q_n), .hold(hold), .vsync_n(vsync_n), .refresh(refresh),
  .cnt(hcount), .hsync_n(hsync_n), .back_porch(back_porch), .csync_n(csync_n),
  .line(line_val), .row_addr(row_addr), .row_oe(row_oe)
);

// File: tb/test_hline_timing.sv
module test_hline_timing;
  logic       clk;
  logic       rst_n;
  logic       hold;
  logic       vsync_n;
  logic       refresh;
  logic [7:0] hcount;
  logic       hsync_n;
  logic       back_porch;
  logic       csync_n;
  logic [2:0] row_addr;
  logic       row_oe;

  int checks;
  int errors;
  bit done;

  hline_timing i_hline_timing (
    .clk(clk), .rst_n(rst_n), .hold(hold), .vsync_n(vsync_n), .refresh(refresh),
    .hcount(hcount), .hsync_n(hsync_n), .back_porch(back_porch), .csync_n(csync_n),
    .row_addr(row_addr), .row_oe(row_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] f_next(input logic [7:0] c, input logic h);
    if (h || c == 8'd207) return 8'd1;
    return c + 8'd1;
  endfunction

  function automatic bit f_sync(input logic [7:0] c);
    return (c >= 8'd192) && (c <= 8'd207);
  endfunction

  // Reference state built from the requirements
  logic       m_s0, m_s1;
  logic [7:0] m_cnt;
  logic [2:0] m_row;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 <= 1'b0; m_s1 <= 1'b0; m_cnt <= 8'd1; m_row <= 3'd0;
    end else begin
      m_s0 <= 1'b1;
      m_s1 <= m_s0;
      if (!m_s1) begin
        m_cnt <= 8'd1; m_row <= 3'd0;
      end else begin
        m_cnt <= f_next(m_cnt, hold);
        if (!vsync_n) m_row <= 3'd0;
        else if (f_sync(m_cnt) && !f_sync(f_next(m_cnt, hold))) m_row <= m_row + 3'd1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (hcount=%0d)", tag, act, exp, hcount);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3 hcount", hcount, m_cnt);
    chk("R5 hsync_n", hsync_n, !f_sync(m_cnt));
    chk("R6 back_porch", back_porch, (m_cnt >= 8'd1 && m_cnt < 8'd16));
    chk("R9 csync_n", csync_n, (!f_sync(m_cnt)) && vsync_n);
    chk("R10 row_oe", row_oe, refresh);
    chk("R7/R8 row_addr", row_addr, refresh ? m_row : 3'd0);
  endtask

  // One cycle: check at the falling edge, then apply new inputs
  task automatic step(input logic h, input logic v, input logic r);
    @(negedge clk);
    compare_all();
    hold = h; vsync_n = v; refresh = r;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hold_left, vs_left, sync_run, sync_len;
    void'($urandom(32'd1234));
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; hold = 1'b0; vsync_n = 1'b1; refresh = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 hcount in reset", hcount, 1);
    chk("R1 hsync_n in reset", hsync_n, 1);
    chk("R1 back_porch in reset", back_porch, 1);
    chk("R1 row in reset", row_addr, 0);
    rst_n = 1'b1;

    // Free run: full lines, 16-clock sync (R5), row wrap after 8 lines (R7)
    sync_run = 0; sync_len = 0;
    for (int i = 0; i < 2000; i++) begin
      step(1'b0, 1'b1, 1'b1);
      if (!hsync_n) sync_run++;
      else if (sync_run != 0) begin sync_len = sync_run; sync_run = 0; end
    end
    chk("R5 sync pulse length", sync_len, 16);

    // R4: hold inside the sync pulse, then inside the active line
    while (hcount != 8'd199) step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1);
    chk("R4 count parked", hcount, 1);
    step(1'b0, 1'b1, 1'b1);
    chk("R4 still parked on release edge", hcount, 1);
    while (hcount != 8'd100) step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0);
    chk("R4 count parked mid line", hcount, 1);

    // R8: vertical sync clears and keeps the row at zero
    for (int i = 0; i < 600; i++) step(1'b0, 1'b0, 1'b1);
    chk("R8 row held under vsync", row_addr, 0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0);
    chk("R10 pads off", row_addr, 0);

    // Random bursts of hold, vsync and refresh
    hold_left = 0; vs_left = 0;
    for (int i = 0; i < 20000; i++) begin
      if (hold_left == 0 && ($urandom % 150) == 0) hold_left = 1 + ($urandom % 20);
      if (vs_left == 0 && ($urandom % 2500) == 0) vs_left = 50 + ($urandom % 400);
      step(hold_left != 0, vs_left == 0, $urandom % 2);
      if (hold_left != 0) hold_left--;
      if (vs_left != 0) vs_left--;
    end
    step(1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule